// File: doc/BRIEF.md
# Shared-Memory Multi-Queue FIFO

This block buffers data in up to eight independent first-in first-out queues that all live in one shared word memory. The memory is divided into equal blocks; at master reset the block latches how many queues are in use and how many blocks each queue owns. Queues are placed back to back in index order, so queue 0 starts at block 0 and every later queue starts right after the one before it. A queue of zero blocks is legal and can never hold data.

A single write port and a single read port each carry a queue-select address. The two selects are independent, and both ports may target the same queue in the same cycle. The write port behaves like a plain FIFO: a full flag describes the queue that is selected for writing, and a write to a full queue is dropped. The read port is first-word-fall-through. Whenever the selected queue holds data, its oldest word is shown on the output with a valid flag, and each enabled read removes the shown word. If the selected queue is empty, the valid flag drops and the output keeps its last word. Each queue has its own almost-full and almost-empty level. The selected queues drive the dedicated almost flags, and two status buses report every queue at once. A partial reset empties one queue.

Top module: `mq_fifo`

## Requirements
- R1: At master reset (`rst` high) the block latches `cfg_nq` (1..8), the per-queue block counts in `cfg_len` (queue i in bits [i*5 +: 5]) and the levels in `cfg_af_lvl` and `cfg_ae_lvl` (queue i in bits [i*9 +: 9]). Queue i holds exactly 16 words for each of its blocks.
- R2: Each queue returns its words in the order they were written, whatever the other queues are doing. A write and a read in the same cycle, to the same queue or to different queues, both take effect.
- R3: `full` is 1 exactly when the queue selected by `wr_q` holds as many words as its depth. A write while `full` is 1 is discarded.
- R4: One cycle after a clock edge at which the queue selected by `rd_q` holds at least one word, `rd_valid` is 1 and `rd_data` is that queue's oldest word. Each cycle with `rd_en` and `rd_valid` both 1 removes that word.
- R5: `rd_en` while `rd_valid` is 0 removes nothing.
- R6: While `rd_valid` is 0, `rd_data` keeps the last value it had, including after the read port switches to an empty queue.
- R7: `almost_full` is 1 when the free space of the selected write queue (depth minus occupancy) is at or below that queue's almost-full level.
- R8: `almost_empty` is 1 when the occupancy of the selected read queue is at or below that queue's almost-empty level. The occupancy counts the word being shown.
- R9: `af_bus[i]` and `ae_bus[i]` apply the R7 and R8 tests to queue i whatever the selects are. Bits for queues at or above the configured count are 0.
- R10: `part_rst` empties queue q only when `wr_q` and `rd_q` both equal q and q is configured. The write and read of that cycle are then dropped. Otherwise `part_rst` has no effect.
- R11: A select at or above the configured queue count never stores or removes data. Such a select reads as `full`=1 and `almost_full`=1 on the write side, and as `rd_valid`=0 and `almost_empty`=1 on the read side.
- R12: A queue of zero blocks always shows `full`=1 and never shows `rd_valid`=1.
- R13: A word written into an empty queue that is also selected for reading appears on `rd_data` with `rd_valid`=1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high; configuration is latched while high |
| cfg_nq | input | 4 | Number of queues in use (1..8) |
| cfg_len | input | 40 | Per-queue block count, 5 bits per queue |
| cfg_af_lvl | input | 72 | Per-queue almost-full level, 9 bits per queue |
| cfg_ae_lvl | input | 72 | Per-queue almost-empty level, 9 bits per queue |
| part_rst | input | 1 | Partial reset of the queue selected on both ports |
| wr_en | input | 1 | Write enable |
| wr_q | input | 3 | Write queue select |
| wr_data | input | 16 | Write data |
| full | output | 1 | Selected write queue is full |
| almost_full | output | 1 | Selected write queue is at or below its free-space level |
| rd_en | input | 1 | Read enable, removes the shown word |
| rd_q | input | 3 | Read queue select |
| rd_data | output | 16 | Head word of the selected read queue |
| rd_valid | output | 1 | `rd_data` is a word of the selected read queue |
| almost_empty | output | 1 | Selected read queue is at or below its occupancy level |
| af_bus | output | 8 | Almost-full status of every queue |
| ae_bus | output | 8 | Almost-empty status of every queue |

## Verification
The hardest case to reach is a single cycle in which the shown word is removed from one queue while the read select moves to another queue, and that other queue is receiving its first word at the same moment. The output register must then take the bypassed write data and not a stale memory word. Directed fills and drains of every queue, with the read select on the queue being filled, reach the bypass and the wrap of each region. A long run with independently random write and read selects, enables and occasional partial resets then puts switching, bypass and same-queue traffic into many cycles. The bench compares every cycle with per-queue word lists kept in the bench.

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int NQ        = 8,
  parameter int DW        = 16,
  parameter int NBLK      = 16,
  parameter int BLK_WORDS = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [$clog2(NQ+1)-1:0]   cfg_nq,
  input  logic [NQ*$clog2(NBLK+1)-1:0] cfg_len,
  input  logic [NQ*$clog2(NBLK*BLK_WORDS+1)-1:0] cfg_af_lvl,
  input  logic [NQ*$clog2(NBLK*BLK_WORDS+1)-1:0] cfg_ae_lvl,
  input  logic                      part_rst,
  input  logic                      wr_en,
  input  logic [$clog2(NQ)-1:0]     wr_q,
  input  logic [DW-1:0]             wr_data,
  output logic                      full,
  output logic                      almost_full,
  input  logic                      rd_en,
  input  logic [$clog2(NQ)-1:0]     rd_q,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_valid,
  output logic                      almost_empty,
  output logic [NQ-1:0]             af_bus,
  output logic [NQ-1:0]             ae_bus
);
  localparam int QW  = $clog2(NQ);
  localparam int NQW = $clog2(NQ+1);
  localparam int LW  = $clog2(NBLK+1);
  localparam int MW  = NBLK*BLK_WORDS;
  localparam int AW  = $clog2(MW);
  localparam int CW  = $clog2(MW+1);

  logic [DW-1:0]  mem [MW];
  logic [NQW-1:0] nq;
  logic [LW-1:0]  len [NQ];
  logic [LW-1:0]  base [NQ];
  logic [LW-1:0]  base_in [NQ];
  logic [CW-1:0]  af_lvl [NQ], ae_lvl [NQ];
  logic [CW-1:0]  cnt [NQ], wp [NQ], rp [NQ];
  logic [CW-1:0]  cnt_n [NQ], wp_n [NQ], rp_n [NQ];
  logic [CW-1:0]  depth [NQ];
  logic [QW-1:0]  rd_cur;
  logic           wsel_ok, rsel_ok, prst_hit, wr_go, rd_go;
  logic [CW-1:0]  wa, ra;
  logic           ld_valid;
  logic [DW-1:0]  ld_data;

  function automatic logic [CW-1:0] step_ptr(input logic [CW-1:0] p, input logic [CW-1:0] d);
    return (p + CW'(1) == d) ? '0 : p + CW'(1);
  endfunction

  always_comb begin
    logic [LW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NQ; i++) begin
      base_in[i] = acc;
      acc = acc + cfg_len[i*LW +: LW];
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign depth[i]  = CW'(len[i]) * CW'(BLK_WORDS);
    assign af_bus[i] = (NQW'(i) < nq) && ((depth[i] - cnt[i]) <= af_lvl[i]);
    assign ae_bus[i] = (NQW'(i) < nq) && (cnt[i] <= ae_lvl[i]);
  end

  assign wsel_ok      = NQW'(wr_q) < nq;
  assign rsel_ok      = NQW'(rd_q) < nq;
  assign full         = !wsel_ok || (cnt[wr_q] == depth[wr_q]);
  assign almost_full  = !wsel_ok || ((depth[wr_q] - cnt[wr_q]) <= af_lvl[wr_q]);
  assign almost_empty = !rsel_ok || (cnt[rd_q] <= ae_lvl[rd_q]);
  assign prst_hit     = part_rst && (wr_q == rd_q) && wsel_ok;
  assign wr_go        = wr_en && !full && !prst_hit;
  assign rd_go        = rd_en && rd_valid && !prst_hit;
  assign wa           = CW'(base[wr_q]) * CW'(BLK_WORDS) + wp[wr_q];

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      cnt_n[i] = cnt[i];
      wp_n[i]  = wp[i];
      rp_n[i]  = rp[i];
      if (wr_go && wr_q == QW'(i)) begin
        cnt_n[i] = cnt_n[i] + CW'(1);
        wp_n[i]  = step_ptr(wp[i], depth[i]);
      end
      if (rd_go && rd_cur == QW'(i)) begin
        cnt_n[i] = cnt_n[i] - CW'(1);
        rp_n[i]  = step_ptr(rp[i], depth[i]);
      end
      if (prst_hit && wr_q == QW'(i)) begin
        cnt_n[i] = '0;
        wp_n[i]  = '0;
        rp_n[i]  = '0;
      end
    end
  end

  assign ra       = CW'(base[rd_q]) * CW'(BLK_WORDS) + rp_n[rd_q];
  assign ld_valid = rsel_ok && (cnt_n[rd_q] != '0);
  assign ld_data  = (wr_go && wa == ra) ? wr_data : mem[ra[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_go) mem[wa[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nq       <= cfg_nq;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_cur   <= '0;
      for (int i = 0; i < NQ; i++) begin
        len[i]    <= cfg_len[i*LW +: LW];
        base[i]   <= base_in[i];
        af_lvl[i] <= cfg_af_lvl[i*CW +: CW];
        ae_lvl[i] <= cfg_ae_lvl[i*CW +: CW];
        cnt[i]    <= '0;
        wp[i]     <= '0;
        rp[i]     <= '0;
      end
    end else begin
      for (int i = 0; i < NQ; i++) begin
        cnt[i] <= cnt_n[i];
        wp[i]  <= wp_n[i];
        rp[i]  <= rp_n[i];
      end
      rd_cur   <= rd_q;
      rd_valid <= ld_valid;
      if (ld_valid) rd_data <= ld_data;
    end
  end

  for (genvar gi = 0; gi < NQ; gi++) begin : g_chk
    // R3
    no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
      cnt[gi] <= depth[gi]);
    // R3
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !part_rst && wr_q == QW'(gi) && cnt[gi] == depth[gi] && !(rd_go && rd_cur == QW'(gi)))
      |=> cnt[gi] == $past(cnt[gi]));
    // R10
    prst_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (part_rst && wr_q == QW'(gi) && rd_q == QW'(gi) && NQW'(gi) < nq) |=> cnt[gi] == '0);
  end

  // R4
  valid_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> cnt[rd_cur] != '0);
  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));
  // R11
  bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !wsel_ok |-> (full && almost_full));
endmodule

// File: tb/tb_mq_fifo.sv
module tb_mq_fifo;
  localparam int NQ = 8, DW = 16, LW = 5, CW = 9, NQC = 5;
  localparam int LEN [NQ] = '{2, 1, 0, 3, 1, 0, 0, 0};
  localparam int AFL [NQ] = '{4, 0, 3, 10, 15, 0, 0, 0};
  localparam int AEL [NQ] = '{2, 0, 1, 5, 0, 0, 0, 0};

  logic clk = 0, rst = 1;
  logic [3:0] cfg_nq = 4'(NQC);
  logic [NQ*LW-1:0] cfg_len;
  logic [NQ*CW-1:0] cfg_af_lvl, cfg_ae_lvl;
  logic part_rst = 0, wr_en = 0, rd_en = 0;
  logic [2:0] wr_q = 0, rd_q = 0;
  logic [DW-1:0] wr_data = 0;
  logic full, almost_full, rd_valid, almost_empty;
  logic [DW-1:0] rd_data;
  logic [NQ-1:0] af_bus, ae_bus;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] mq [NQ][$];
  bit exp_valid = 0;
  logic [DW-1:0] exp_data = 0;
  int disp_q = 0;

  always #2 clk = ~clk;

  mq_fifo dut (.clk(clk), .rst(rst), .cfg_nq(cfg_nq), .cfg_len(cfg_len),
    .cfg_af_lvl(cfg_af_lvl), .cfg_ae_lvl(cfg_ae_lvl), .part_rst(part_rst),
    .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data), .full(full),
    .almost_full(almost_full), .rd_en(rd_en), .rd_q(rd_q), .rd_data(rd_data),
    .rd_valid(rd_valid), .almost_empty(almost_empty), .af_bus(af_bus), .ae_bus(ae_bus));

  function automatic int dep(int q);
    return (q < NQC) ? LEN[q] * 16 : 0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    int w = int'(wr_q), r = int'(rd_q);
    bit ef, eaf, eae;
    logic [NQ-1:0] eafb, eaeb;
    ef  = (w >= NQC) || (mq[w].size() == dep(w));
    eaf = (w >= NQC) || (dep(w) - mq[w].size() <= AFL[w]);
    eae = (r >= NQC) || (mq[r].size() <= AEL[r]);
    for (int i = 0; i < NQ; i++) begin
      eafb[i] = (i < NQC) && (dep(i) - mq[i].size() <= AFL[i]);
      eaeb[i] = (i < NQC) && (mq[i].size() <= AEL[i]);
    end
    check(full == ef, (w >= NQC) ? "R11" : (dep(w) == 0 ? "R12" : "R3"), "full", int'(full), int'(ef));
    check(almost_full == eaf, "R7", "almost_full", int'(almost_full), int'(eaf));
    check(almost_empty == eae, "R8", "almost_empty", int'(almost_empty), int'(eae));
    check(af_bus == eafb, "R9", "af_bus", int'(af_bus), int'(eafb));
    check(ae_bus == eaeb, "R9", "ae_bus", int'(ae_bus), int'(eaeb));
    check(rd_valid == exp_valid, "R4", "rd_valid", int'(rd_valid), int'(exp_valid));
    check(rd_data == exp_data, exp_valid ? "R2" : "R6", "rd_data", int'(rd_data), int'(exp_data));
  endtask

  task automatic step();
    int w = int'(wr_q), r = int'(rd_q);
    bit ph, wok, rok;
    ph  = part_rst && (w == r) && (w < NQC);
    wok = wr_en && (w < NQC) && (mq[w].size() < dep(w)) && !ph;
    rok = rd_en && exp_valid && !ph;
    if (ph) mq[w].delete();
    if (rok) void'(mq[disp_q].pop_front());
    if (wok) mq[w].push_back(wr_data);
    disp_q = r;
    if (r < NQC && mq[r].size() > 0) begin
      exp_valid = 1;
      exp_data  = mq[r][0];
    end else exp_valid = 0;
    @(posedge clk);
    #1;
    check_outputs();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NQ; i++) begin
      cfg_len[i*LW +: LW]    = LW'(LEN[i]);
      cfg_af_lvl[i*CW +: CW] = CW'(AFL[i]);
      cfg_ae_lvl[i*CW +: CW] = CW'(AEL[i]);
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state: every queue empty
    check_outputs();

    // R1 R3 R12 R11 R13: fill each select past its depth, read select on it
    for (int q = 0; q < NQ; q++) begin
      wr_q = 3'(q); rd_q = 3'(q); wr_en = 1; rd_en = 0;
      for (int k = 0; k < dep(q) + 2; k++) begin
        wr_data = DW'((q << 12) | k);
        step();
      end
      check(full == 1'b1, "R3", "full after fill", int'(full), 1);
      check(mq[q].size() == dep(q), "R1", "stored words", mq[q].size(), dep(q));
      // R5: drain past empty
      wr_en = 0; rd_en = 1;
      for (int k = 0; k < dep(q) + 3; k++) step();
      rd_en = 0;
    end

    // R6: word in queue 0, then switch to empty queue 1
    wr_q = 0; rd_q = 0; wr_en = 1; wr_data = 16'hBEEF; step();
    wr_en = 0; step();
    rd_q = 1; step();
    check(rd_data == 16'hBEEF && !rd_valid, "R6", "held word", int'(rd_data), 16'hBEEF);
    rd_q = 0; step();

    // R10: part_rst with differing selects has no effect, then clears
    wr_q = 3; wr_en = 1;
    for (int k = 0; k < 7; k++) begin wr_data = DW'(16'h3300 + k); step(); end
    wr_en = 0; rd_q = 1; part_rst = 1; step();
    check(mq[3].size() == 7, "R10", "no clear", mq[3].size(), 7);
    rd_q = 3; step();
    part_rst = 0; step();
    check(rd_valid == 1'b0, "R10", "cleared queue valid", int'(rd_valid), 0);

    // R2: random mixed traffic
    for (int n = 0; n < 6000; n++) begin
      wr_q = 3'($urandom_range(0, 7));
      rd_q = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : rd_q;
      wr_en = $urandom_range(0, 2) != 0;
      rd_en = $urandom_range(0, 2) != 0;
      wr_data = DW'($urandom);
      part_rst = ($urandom_range(0, 60) == 0);
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule